// File: doc/BRIEF.md
# UART Auxiliary Configuration Register Bank

This block holds the side-band configuration registers that sit next to a 16550-style serial core. It has eight writable registers: two operating-mode bytes, a supplementary control byte, an extended break length, an oscillator select bit, a system configuration byte, a wakeup-enable mask and a clock prescaler. It also has three addresses that always return fixed values: a supplementary status, a version code and a reset-complete status. The serial shifter, the baud generator, interrupts and DMA are not part of it.

A host reaches the bank over a plain synchronous bus with address, write enable, write data, read enable and read data. Only the low eight address bits select a register. Each register keeps only its own subset of the written bits. Writing the system configuration register with bit 1 set performs a partial soft reset. Two one-cycle error pulses report bad accesses: one for a write to a fixed-value address, and one for any access to an address that holds no register.

Top module: `uart_aux_cfg`

## Requirements
- R1: After hardware reset every register reads zero, except wakeup enable (0x5C), which reads 0x3F, and prescaler (0x60), which reads 0x69.
- R2: Only address bits [7:0] select a register; the same low byte with any upper address bits reaches the same register.
- R3: Stored bits per write: mode-A (0x20) keeps bits [6:0], wakeup enable (0x5C) keeps [6:0], oscillator select (0x4C) keeps bit 0 only; mode-B (0x24), supplementary control (0x40), break length (0x48) and prescaler (0x60) keep all eight bits; write-data bits above [7:0] are ignored.
- R4: A write to system configuration (0x54) with bit 1 clear stores the value ANDed with 0x1D.
- R5: A write to 0x54 with bit 1 set loads break length 0x00, system configuration 0x00, wakeup enable 0x3F, prescaler 0x69 and oscillator select 0; the reset value wins over the written value, so 0x54 then reads 0x00.
- R6: The soft reset of R5 leaves mode-A (0x20), mode-B (0x24) and supplementary control (0x40) unchanged.
- R7: Address 0x44 always reads 0x00, 0x50 always reads 0x30 and 0x58 always reads 0x01.
- R8: A write to 0x44, 0x50 or 0x58 changes nothing and raises `roErr` for exactly the one cycle after the write.
- R9: A read or write to any low-byte address not listed in R1 to R8 reads 0x00, changes no register, and raises `addrErr` for exactly the one cycle after the access.
- R10: `busRdata` is loaded on the clock edge where `busRe` is high, zero-extended above bit 7, and holds its value while `busRe` is low. A write takes effect on the edge where `busWe` is high, so a read of the same register in the same cycle returns the value it had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| busAddr | input | ADDR_W | Byte address; only [7:0] is decoded |
| busWe | input | 1 | Write enable |
| busWdata | input | DATA_W | Write data; only [7:0] is used |
| busRe | input | 1 | Read enable |
| busRdata | output | DATA_W | Registered read data |
| roErr | output | 1 | One-cycle pulse after a write to a fixed-value address |
| addrErr | output | 1 | One-cycle pulse after an access to an address with no register |

## Verification
The bench builds the block with ADDR_W=12 and DATA_W=32. The four extra address bits carry a changing alias pattern, so every access also exercises the low-byte-only decode. The wide data path shows that write bits above [7:0] are dropped and that read data is zero above bit 7. This small configuration allows every byte value to be written to every register and every one of the 256 low addresses to be swept, with expected values taken from mask and reset tables kept in the bench.

// File: rtl/uart_aux_pkg.sv
`timescale 1ns/1ps
package uart_aux_pkg;

  localparam int DEC_W     = 8;
  localparam int NUM_REGS  = 8;
  localparam int NUM_CONST = 3;
  localparam int SYSCFG_IDX   = 5;
  localparam int SOFT_RST_BIT = 1;

  typedef struct packed {
    logic [DEC_W-1:0] addr;
    logic [7:0]       mask;
    logic [7:0]       hwRst;
    logic [7:0]       swRst;
    logic             swAffect;
  } regDesc_t;

  // index order: modeA, modeB, supCtl, brkLen, oscSel, sysCfg, wakeEn, prescale
  localparam regDesc_t REG_DESC [NUM_REGS] = '{
    '{8'h20, 8'h7F, 8'h00, 8'h00, 1'b0},
    '{8'h24, 8'hFF, 8'h00, 8'h00, 1'b0},
    '{8'h40, 8'hFF, 8'h00, 8'h00, 1'b0},
    '{8'h48, 8'hFF, 8'h00, 8'h00, 1'b1},
    '{8'h4C, 8'h01, 8'h00, 8'h00, 1'b1},
    '{8'h54, 8'h1D, 8'h00, 8'h00, 1'b1},
    '{8'h5C, 8'h7F, 8'h3F, 8'h3F, 1'b1},
    '{8'h60, 8'hFF, 8'h69, 8'h69, 1'b1}
  };

  typedef struct packed {
    logic [DEC_W-1:0] addr;
    logic [7:0]       value;
  } constDesc_t;

  localparam constDesc_t CONST_DESC [NUM_CONST] = '{
    '{8'h44, 8'h00},
    '{8'h50, 8'h30},
    '{8'h58, 8'h01}
  };

  typedef struct packed {
    logic [NUM_REGS-1:0] wrEn;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdEn;
    logic                constRd;
    logic [7:0]          constData;
    logic                softRst;
  } strobe_t;

endpackage

// File: rtl/uart_aux_field.sv
`timescale 1ns/1ps
module uart_aux_field #(
  parameter logic [7:0] MASK      = 8'hFF,
  parameter logic [7:0] HW_RST    = 8'h00,
  parameter logic [7:0] SW_RST    = 8'h00,
  parameter bit         SW_AFFECT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       wrEn,
  input  logic [7:0] wdata,
  output logic [7:0] q
);

  logic swHit;

  generate
    if (SW_AFFECT) begin : g_soft
      assign swHit = softRst;
    end else begin : g_keep
      assign swHit = 1'b0;
    end
  endgenerate

  // soft reset outranks a write landing on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       q <= HW_RST;
    else if (swHit)  q <= SW_RST;
    else if (wrEn)   q <= wdata & MASK;
  end

endmodule

// File: rtl/uart_aux_ctrl.sv
`timescale 1ns/1ps
module uart_aux_ctrl
  import uart_aux_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEC_W-1:0] addrLow,
  input  logic             we,
  input  logic             re,
  input  logic             softBit,
  output strobe_t          strb,
  output logic             roErr,
  output logic             addrErr
);

  logic [NUM_REGS-1:0] regHit;
  logic                constHit;
  logic [7:0]          constVal;
  logic                known;

  always_comb begin
    regHit = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      regHit[i] = (addrLow == REG_DESC[i].addr);
    end
  end

  always_comb begin
    constHit = 1'b0;
    constVal = 8'h00;
    for (int k = 0; k < NUM_CONST; k++) begin
      if (addrLow == CONST_DESC[k].addr) begin
        constHit = 1'b1;
        constVal = CONST_DESC[k].value;
      end
    end
  end

  assign known = (|regHit) | constHit;

  always_comb begin
    strb           = '0;
    strb.wrEn      = we ? regHit : '0;
    strb.rdSel     = regHit;
    strb.rdEn      = re;
    strb.constRd   = constHit;
    strb.constData = constVal;
    strb.softRst   = we & regHit[SYSCFG_IDX] & softBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roErr   <= 1'b0;
      addrErr <= 1'b0;
    end else begin
      roErr   <= we & constHit;
      addrErr <= (we | re) & ~known;
    end
  end

endmodule

// File: rtl/uart_aux_dp.sv
`timescale 1ns/1ps
module uart_aux_dp
  import uart_aux_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - 8;

  logic [7:0] regQ [NUM_REGS];
  logic [7:0] rdByte;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      uart_aux_field #(
        .MASK      (REG_DESC[g].mask),
        .HW_RST    (REG_DESC[g].hwRst),
        .SW_RST    (REG_DESC[g].swRst),
        .SW_AFFECT (REG_DESC[g].swAffect)
      ) u_field (
        .clk     (clk),
        .rstN    (rstN),
        .softRst (strb.softRst),
        .wrEn    (strb.wrEn[g]),
        .wdata   (wdata),
        .q       (regQ[g])
      );
    end
  endgenerate

  always_comb begin
    rdByte = strb.constRd ? strb.constData : 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.rdSel[i]) rdByte = rdByte | regQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= {{PAD_W{1'b0}}, rdByte};
  end

endmodule

// File: rtl/uart_aux_cfg.sv
`timescale 1ns/1ps
module uart_aux_cfg
  import uart_aux_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              roErr,
  output logic              addrErr
);

  strobe_t strb;
  logic    unusedAddrHi;
  logic    unusedDataHi;

  assign unusedAddrHi = ^busAddr[ADDR_W-1:DEC_W];
  assign unusedDataHi = ^busWdata[DATA_W-1:8];

  uart_aux_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addrLow (busAddr[DEC_W-1:0]),
    .we      (busWe),
    .re      (busRe),
    .softBit (busWdata[SOFT_RST_BIT]),
    .strb    (strb),
    .roErr   (roErr),
    .addrErr (addrErr)
  );

  uart_aux_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata[7:0]),
    .rdata (busRdata)
  );

endmodule

// File: rtl/uart_aux_chk.sv
`timescale 1ns/1ps
module uart_aux_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        addrLow,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic              roErr,
  input logic              addrErr
);

  function automatic logic isMapped(input logic [7:0] a);
    case (a)
      8'h20, 8'h24, 8'h40, 8'h44, 8'h48, 8'h4C,
      8'h50, 8'h54, 8'h58, 8'h5C, 8'h60: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(roErr && addrErr)); // R8

  AST_RO_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    roErr |-> $past(busWe)); // R8

  AST_BAD_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> ($past(busWe) || $past(busRe))); // R9

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !isMapped(addrLow)) |=> (busRdata == '0)); // R9

  AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && addrLow == 8'h50) |=> (busRdata == DATA_W'(8'h30))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata)); // R10

  AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:8] == '0); // R10

endmodule

bind uart_aux_cfg uart_aux_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrLow  (busAddr[7:0]),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRdata (busRdata),
  .roErr    (roErr),
  .addrErr  (addrErr)
);

// File: tb/test_uart_aux_cfg.sv
`timescale 1ns/1ps
module test_uart_aux_cfg;

  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic          busRe = 1'b0;
  logic [DW-1:0] busRdata;
  logic          roErr;
  logic          addrErr;

  int nVec = 0;
  int nMis = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  uart_aux_cfg #(.ADDR_W(AW), .DATA_W(DW)) i_uart_aux_cfg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .roErr(roErr), .addrErr(addrErr)
  );

  function automatic int idxOf(input logic [7:0] a);
    case (a)
      8'h20: return 0;  8'h24: return 1;  8'h40: return 2;  8'h48: return 3;
      8'h4C: return 4;  8'h54: return 5;  8'h5C: return 6;  8'h60: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] maskOf(input int i);
    case (i)
      0: return 8'h7F;  4: return 8'h01;  5: return 8'h1D;  6: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int constOf(input logic [7:0] a);
    case (a)
      8'h44: return 8'h00;  8'h50: return 8'h30;  8'h58: return 8'h01;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (constOf(a) >= 0) return 8'(constOf(a));
    if (idxOf(a) >= 0)   return model[idxOf(a)];
    return 8'h00;
  endfunction

  task automatic modelHwReset();
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    model[6] = 8'h3F;
    model[7] = 8'h69;
  endtask

  task automatic modelSoftReset();
    model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
    model[6] = 8'h3F; model[7] = 8'h69;
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    int i;
    i = idxOf(a);
    if (i == 5 && d[1]) modelSoftReset();
    else if (i >= 0)    model[i] = d & maskOf(i);
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nVec++;
    if (got !== exp) begin
      nMis++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [3:0] hi, input logic [7:0] d,
                          output logic ro, output logic bad);
    @(negedge clk);
    busAddr = {hi, a}; busWdata = {24'hC3A55A, d}; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    ro = roErr; bad = addrErr;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [7:0] a, input logic [3:0] hi,
                         output logic [DW-1:0] q, output logic bad);
    @(negedge clk);
    busAddr = {hi, a}; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    q = busRdata; bad = addrErr;
  endtask

  task automatic checkAll(input string tag);
    logic [DW-1:0] q;
    logic bad;
    for (int a = 0; a < 256; a++) begin
      if (idxOf(8'(a)) >= 0 || constOf(8'(a)) >= 0) begin
        busRead(8'(a), 4'(a), q, bad);
        chk(tag, q, DW'(expRead(8'(a))));
      end
    end
  endtask

  initial begin
    #2_000_000;
    nMis++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

  initial begin
    logic [DW-1:0] q;
    logic ro, bad;
    modelHwReset();
    repeat (3) @(negedge clk);
    chk("R1 rdata at reset", busRdata, '0);
    chk("R1 roErr at reset", DW'(roErr), '0);
    chk("R1 addrErr at reset", DW'(addrErr), '0);
    rstN = 1'b1;

    // R1 and R7: every mapped address after hardware reset
    checkAll("R1/R7 reset readback");

    // R2, R3, R4: full byte sweep on each register, upper address bits vary
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] a;
        case (i)
          0: a = 8'h20; 1: a = 8'h24; 2: a = 8'h40; 3: a = 8'h48;
          4: a = 8'h4C; 5: a = 8'h54; 6: a = 8'h5C; default: a = 8'h60;
        endcase
        busWrite(a, 4'(v), 8'(v), ro, bad);
        busRead(a, 4'(v + 7), q, bad);
        if (i == 5) chk("R4/R5 sysCfg write", q, DW'(expRead(a)));
        else        chk("R2/R3 masked write", q, DW'(expRead(a)));
      end
    end

    // R5 and R6: set everything away from reset, then soft reset
    busWrite(8'h20, 4'h1, 8'h5A, ro, bad);
    busWrite(8'h24, 4'h2, 8'hA7, ro, bad);
    busWrite(8'h40, 4'h3, 8'h3C, ro, bad);
    busWrite(8'h48, 4'h4, 8'hEE, ro, bad);
    busWrite(8'h4C, 4'h5, 8'hFF, ro, bad);
    busWrite(8'h54, 4'h6, 8'h1D, ro, bad);
    busWrite(8'h5C, 4'h7, 8'h11, ro, bad);
    busWrite(8'h60, 4'h8, 8'h02, ro, bad);
    checkAll("R3/R4 preset");
    busWrite(8'h54, 4'h9, 8'hFF, ro, bad);
    busRead(8'h54, 4'h0, q, bad); chk("R5 sysCfg after soft reset", q, 32'h00);
    busRead(8'h48, 4'h0, q, bad); chk("R5 brkLen after soft reset", q, 32'h00);
    busRead(8'h5C, 4'h0, q, bad); chk("R5 wakeEn after soft reset", q, 32'h3F);
    busRead(8'h60, 4'h0, q, bad); chk("R5 prescale after soft reset", q, 32'h69);
    busRead(8'h4C, 4'h0, q, bad); chk("R5 oscSel after soft reset", q, 32'h00);
    busRead(8'h20, 4'h0, q, bad); chk("R6 modeA kept", q, 32'h5A);
    busRead(8'h24, 4'h0, q, bad); chk("R6 modeB kept", q, 32'hA7);
    busRead(8'h40, 4'h0, q, bad); chk("R6 supCtl kept", q, 32'h3C);

    // R7 and R8: writes to fixed addresses
    for (int k = 0; k < 3; k++) begin
      logic [7:0] a;
      a = (k == 0) ? 8'h44 : (k == 1) ? 8'h50 : 8'h58;
      busWrite(a, 4'(k), 8'hFF, ro, bad);
      chk("R8 roErr raised", DW'(ro), 32'h1);
      chk("R8 no addrErr", DW'(bad), 32'h0);
      @(negedge clk);
      chk("R8 roErr one cycle", DW'(roErr), 32'h0);
      busRead(a, 4'hF, q, bad);
      chk("R7 constant kept", q, DW'(expRead(a)));
    end
    checkAll("R8 nothing changed");

    // R9: sweep every low address
    for (int a = 0; a < 256; a++) begin
      if (idxOf(8'(a)) < 0 && constOf(8'(a)) < 0) begin
        busWrite(8'(a), 4'(a), 8'hFF, ro, bad);
        chk("R9 write addrErr", DW'(bad), 32'h1);
        chk("R9 write no roErr", DW'(ro), 32'h0);
        busRead(8'(a), 4'(a), q, bad);
        chk("R9 read zero", q, 32'h0);
        chk("R9 read addrErr", DW'(bad), 32'h1);
        @(negedge clk);
        chk("R9 addrErr one cycle", DW'(addrErr), 32'h0);
      end else begin
        busRead(8'(a), 4'(a), q, bad);
        chk("R9 mapped no addrErr", DW'(bad), 32'h0);
      end
    end
    checkAll("R9 nothing changed");

    // R10: hold while idle, read-before-write in the same cycle
    busWrite(8'h24, 4'h0, 8'h81, ro, bad);
    busRead(8'h24, 4'h0, q, bad);
    @(negedge clk); busAddr = 12'h050;
    @(negedge clk); busAddr = 12'h0AB;
    @(negedge clk);
    chk("R10 rdata holds", busRdata, 32'h81);
    @(negedge clk);
    busAddr = 12'h024; busWdata = 32'h0000_0042; busWe = 1'b1; busRe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
    chk("R10 same-cycle read sees old", busRdata, 32'h81);
    modelWrite(8'h24, 8'h42);
    busRead(8'h24, 4'h3, q, bad);
    chk("R10 write took effect", q, 32'h42);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

endmodule